// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block forms the program counter for subroutine calls, returns and short relative jumps in a small 8-bit controller, and moves return addresses to and from the on-chip stack. After decode it receives a command code, the up to three instruction bytes and the address of the instruction being run. It computes the next program counter, keeps an 8-bit stack pointer and drives one byte-wide port into the internal data RAM.

Every accepted command takes a fixed sequence. Two cycles of RAM access follow the accepting edge: a call pushes two bytes, a return pops two bytes, and a short jump leaves the RAM untouched. In the third cycle a one-cycle `done_o` pulse marks that `pc_o` and `sp_o` hold the new values. The stack grows upward. Each push increments the pointer first and then writes. A return that ends interrupt service also pulses a release strobe for the interrupt controller. The status word is never saved or restored here.

Top module: `pcs_top`

## Requirements
- R1: While `rst_ni` is low and after it rises, `pc_o` is 0000h, `sp_o` is 07h, and `done_o`, `irq_rel_o`, `ram_we_o` and `ram_re_o` are 0.
- R2: A call pushes the return address low byte first. The low byte goes to address SP+1 and the high byte to SP+2, in two consecutive write cycles. SP ends two higher than before.
- R3: `cmd_i`=1 (absolute call) uses return address `pc_i`+2. Its target is formed from bits 15..11 of that return address, then bits 7..5 of `ins0_i`, then `ins1_i` as bits 7..0.
- R4: `cmd_i`=2 (long call) uses return address `pc_i`+3. Its target is `{ins1_i, ins2_i}`.
- R5: `cmd_i`=3 (return) reads the high byte at SP and the low byte at SP-1. RAM read data is taken in the same cycle as `ram_re_o`. `pc_o` becomes the popped address and SP ends two lower.
- R6: `cmd_i`=4 (interrupt return) behaves like R5 and raises `irq_rel_o` for exactly the `done_o` cycle. No other command raises `irq_rel_o`.
- R7: `cmd_i`=5 (short jump) sets `pc_o` to `pc_i`+2 plus `ins1_i` taken as a signed 8-bit value, modulo 2^16. It performs no RAM access and leaves SP unchanged.
- R8: SP wraps modulo 256 on both push and pop, with no overflow detection.
- R9: A command is accepted on a rising edge where `cmd_valid_i` is 1 and the sequencer is idle. `done_o` is then high for one cycle, in the third cycle after that edge, and `pc_o` and `sp_o` show the new values in that same cycle.
- R10: `cmd_valid_i` is ignored during the two access cycles after acceptance. Codes 0, 6 and 7 are never accepted. Neither case changes `pc_o` or `sp_o` or produces `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_i | input | 3 | Command code (1 acall, 2 lcall, 3 ret, 4 reti, 5 sjmp) |
| pc_i | input | 16 | Address of the first byte of the instruction |
| ins0_i | input | 8 | Instruction byte 0 (opcode with page bits in 7..5) |
| ins1_i | input | 8 | Instruction byte 1 |
| ins2_i | input | 8 | Instruction byte 2 |
| ram_rdata_i | input | 8 | RAM read data, valid in the cycle of the read |
| ram_we_o | output | 1 | RAM write enable |
| ram_re_o | output | 1 | RAM read enable |
| ram_addr_o | output | 8 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| pc_o | output | 16 | Program counter after the last command |
| sp_o | output | 8 | Stack pointer |
| done_o | output | 1 | One-cycle pulse: new PC and SP valid |
| irq_rel_o | output | 1 | Interrupt level release pulse |

## Verification
The hardest case to reach is stack pointer wrap. SP starts at 07h and only changes in steps of two, so it can only reach the top of the range by a run of unmatched returns. The bench issues four returns from reset to bring SP to FFh. It then checks that a long call writes its bytes to 00h and 01h, and that a following return reads them back across the wrap. A second hard case is a command that arrives while a sequence is busy. For that, the bench holds `cmd_valid_i` high through both access cycles with a different code and checks that only the first command takes effect.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_ACALL = 3'd1,
    CMD_LCALL = 3'd2,
    CMD_RET   = 3'd3,
    CMD_RETI  = 3'd4,
    CMD_SJMP  = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STEP1 = 2'd1,
    ST_STEP2 = 2'd2
  } st_e;
endpackage

// File: rtl/pcs_target.sv
module pcs_target
  import pcs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 11,
  localparam int PC_W  = 2 * DATA_W,
  localparam int HI_W  = PAGE_W - DATA_W
) (
  input  logic [2:0]        cmd_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] ins0_i,
  input  logic [DATA_W-1:0] ins1_i,
  input  logic [DATA_W-1:0] ins2_i,
  output logic [PC_W-1:0]   ret_o,
  output logic [PC_W-1:0]   tgt_o
);
  logic [PC_W-1:0] len;
  logic [PC_W-1:0] rel;

  always_comb begin
    unique case (cmd_e'(cmd_i))
      CMD_LCALL:          len = PC_W'(3);
      CMD_ACALL, CMD_SJMP: len = PC_W'(2);
      default:            len = PC_W'(1);
    endcase
  end

  assign ret_o = pc_i + len;
  assign rel   = {{(PC_W-DATA_W){ins1_i[DATA_W-1]}}, ins1_i};

  always_comb begin
    unique case (cmd_e'(cmd_i))
      CMD_ACALL: tgt_o = {ret_o[PC_W-1:PAGE_W], ins0_i[DATA_W-1 -: HI_W], ins1_i};
      CMD_LCALL: tgt_o = {ins1_i, ins2_i};
      CMD_SJMP:  tgt_o = ret_o + rel;
      default:   tgt_o = '0;
    endcase
  end
endmodule

// File: rtl/pcs_sp.sv
module pcs_sp #(
  parameter int              SP_W   = 8,
  parameter logic [SP_W-1:0] SP_RST = 8'h07
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inc_i,
  input  logic            dec_i,
  output logic [SP_W-1:0] sp_o,
  output logic [SP_W-1:0] sp_inc_o
);
  logic [SP_W-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_q <= SP_RST;
    else if (inc_i) sp_q <= sp_q + SP_W'(1);
    else if (dec_i) sp_q <= sp_q - SP_W'(1);
  end

  assign sp_o     = sp_q;
  assign sp_inc_o = sp_q + SP_W'(1);

  AST_SP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !dec_i) |=> $stable(sp_q)); // R7
  AST_SP_NO_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_i && dec_i)); // R8
endmodule

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [2:0] cmd_i,
  output logic       accept_o,
  output logic       push_o,
  output logic       pop_o,
  output logic       step1_o,
  output logic       step2_o,
  output logic       done_o,
  output logic       rel_o
);
  st_e  st_q, st_d;
  cmd_e cmd_q;
  logic legal, busy, is_call, is_ret;
  logic done_q, rel_q;

  assign legal    = (cmd_i >= 3'd1) && (cmd_i <= 3'd5);
  assign accept_o = valid_i && legal && (st_q == ST_IDLE);
  assign busy     = (st_q != ST_IDLE);
  assign is_call  = (cmd_q == CMD_ACALL) || (cmd_q == CMD_LCALL);
  assign is_ret   = (cmd_q == CMD_RET) || (cmd_q == CMD_RETI);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept_o) st_d = ST_STEP1;
      ST_STEP1: st_d = ST_STEP2;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cmd_q  <= CMD_NONE;
      done_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      if (accept_o) cmd_q <= cmd_e'(cmd_i);
      done_q <= (st_q == ST_STEP2);
      rel_q  <= (st_q == ST_STEP2) && (cmd_q == CMD_RETI);
    end
  end

  assign push_o  = busy && is_call;
  assign pop_o   = busy && is_ret;
  assign step1_o = (st_q == ST_STEP1);
  assign step2_o = (st_q == ST_STEP2);
  assign done_o  = done_q;
  assign rel_o   = rel_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_REL_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_o |-> done_o); // R6
  AST_SJMP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cmd_q == CMD_SJMP) |-> (!push_o && !pop_o)); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step1_o |=> step2_o); // R10
endmodule

// File: rtl/pcs_top.sv
module pcs_top
  import pcs_pkg::*;
#(
  parameter int   DATA_W = 8,
  parameter int   PAGE_W = 11,
  parameter logic [7:0] SP_RST = 8'h07,
  localparam int  PC_W   = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] ins0_i,
  input  logic [DATA_W-1:0] ins1_i,
  input  logic [DATA_W-1:0] ins2_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              ram_we_o,
  output logic              ram_re_o,
  output logic [DATA_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [DATA_W-1:0] sp_o,
  output logic              done_o,
  output logic              irq_rel_o
);
  logic              accept, push, pop, step1, step2;
  logic [PC_W-1:0]   ret_c, tgt_c, ret_q, tgt_q, pc_q;
  logic [DATA_W-1:0] sp, sp_inc, hi_q;

  pcs_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (cmd_valid_i),
    .cmd_i    (cmd_i),
    .accept_o (accept),
    .push_o   (push),
    .pop_o    (pop),
    .step1_o  (step1),
    .step2_o  (step2),
    .done_o   (done_o),
    .rel_o    (irq_rel_o)
  );

  pcs_target #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_tgt (
    .cmd_i  (cmd_i),
    .pc_i   (pc_i),
    .ins0_i (ins0_i),
    .ins1_i (ins1_i),
    .ins2_i (ins2_i),
    .ret_o  (ret_c),
    .tgt_o  (tgt_c)
  );

  pcs_sp #(.SP_W(DATA_W), .SP_RST(SP_RST)) u_sp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (push),
    .dec_i    (pop),
    .sp_o     (sp),
    .sp_inc_o (sp_inc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_q <= '0;
      tgt_q <= '0;
      hi_q  <= '0;
      pc_q  <= '0;
    end else begin
      if (accept) begin
        ret_q <= ret_c;
        tgt_q <= tgt_c;
      end
      if (pop && step1) hi_q <= ram_rdata_i;
      if (step2) pc_q <= pop ? {hi_q, ram_rdata_i} : tgt_q;
    end
  end

  // pre-increment push, post-decrement pop
  assign ram_we_o    = push;
  assign ram_re_o    = pop;
  assign ram_addr_o  = push ? sp_inc : sp;
  assign ram_wdata_o = step2 ? ret_q[PC_W-1:DATA_W] : ret_q[DATA_W-1:0];
  assign pc_o        = pc_q;
  assign sp_o        = sp;

  AST_PUSH_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o && $past(ram_we_o)) |-> (ram_addr_o == DATA_W'($past(ram_addr_o) + 1'b1))); // R2
  AST_POP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_re_o && $past(ram_re_o)) |-> (ram_addr_o == DATA_W'($past(ram_addr_o) - 1'b1))); // R5
  AST_ONE_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && ram_re_o)); // R2
  AST_PC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(step2)) |-> $stable(pc_o)); // R10
endmodule

// File: tb/sim_pcs_top.sv
`timescale 1ns/1ps
module sim_pcs_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [15:0] pc_in = 16'h0;
  logic [7:0]  b0 = 8'h0, b1 = 8'h0, b2 = 8'h0;
  logic [7:0]  rdata, addr, wdata;
  logic        we, re, done, rel;
  logic [15:0] pc;
  logic [7:0]  sp;
  logic [7:0]  mem [256];
  int n_chk = 0;
  int n_bad = 0;
  int lat;

  always #2 clk = ~clk;

  pcs_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_i(cmd), .pc_i(pc_in),
    .ins0_i(b0), .ins1_i(b1), .ins2_i(b2), .ram_rdata_i(rdata),
    .ram_we_o(we), .ram_re_o(re), .ram_addr_o(addr), .ram_wdata_o(wdata),
    .pc_o(pc), .sp_o(sp), .done_o(done), .irq_rel_o(rel)
  );

  assign rdata = mem[addr];
  always @(posedge clk) if (we) mem[addr] <= wdata;

  // {cmd, pc, b0, b1, b2, exp_pc, exp_sp, exp_rel}
  localparam logic [67:0] VEC [9] = '{
    {3'd1, 16'h0230, 8'hB1, 8'h67, 8'h00, 16'h0567, 8'h09, 1'b0},
    {3'd2, 16'h0230, 8'h00, 8'h41, 8'h00, 16'h4100, 8'h0B, 1'b0},
    {3'd5, 16'h0100, 8'h00, 8'h1E, 8'h00, 16'h0120, 8'h0B, 1'b0},
    {3'd5, 16'h0100, 8'h00, 8'h80, 8'h00, 16'h0082, 8'h0B, 1'b0},
    {3'd3, 16'h0000, 8'h00, 8'h00, 8'h00, 16'h0233, 8'h09, 1'b0},
    {3'd4, 16'h0000, 8'h00, 8'h00, 8'h00, 16'h0232, 8'h07, 1'b1},
    {3'd1, 16'h0FFE, 8'h11, 8'h34, 8'h00, 16'h1034, 8'h09, 1'b0},
    {3'd5, 16'hFFF0, 8'h00, 8'h7F, 8'h00, 16'h0071, 8'h09, 1'b0},
    {3'd3, 16'h0000, 8'h00, 8'h00, 8'h00, 16'h1000, 8'h07, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // issue one command; hold valid with alt code for hold cycles after acceptance
  task automatic run(input logic [2:0] c, input logic [15:0] p, input logic [7:0] x0,
                     input logic [7:0] x1, input logic [7:0] x2,
                     input int hold, input logic [2:0] alt);
    @(negedge clk);
    valid = 1'b1; cmd = c; pc_in = p; b0 = x0; b1 = x1; b2 = x2;
    @(posedge clk);
    lat = 0;
    while (1) begin
      @(negedge clk);
      lat++;
      if (done || lat > 20) break;
      if (lat <= hold) begin valid = 1'b1; cmd = alt; end
      else valid = 1'b0;
    end
    valid = 1'b0;
    chk("R9 latency", 32'(lat), 32'd3);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL R9 watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", 32'(pc), 32'h0000);
    chk("R1 sp in reset", 32'(sp), 32'h07);
    chk("R1 strobes in reset", {28'd0, done, rel, we, re}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 sp after reset", 32'(sp), 32'h07);
    chk("R1 done after reset", 32'(done), 32'h0);

    // R2 R3 R4 R5 R6 R7 vector walk
    for (int v = 0; v < 9; v++) begin
      logic [67:0] e;
      e = VEC[v];
      run(e[67:65], e[64:49], e[48:41], e[40:33], e[32:25], 0, 3'd0);
      chk("R2-5,R7 vector pc (R3 R4 R5 R7)", 32'(pc), 32'(e[24:9]));
      chk("R2 R5 vector sp", 32'(sp), 32'(e[8:1]));
      chk("R6 release", 32'(rel), 32'(e[0]));
    end
    chk("R4 lcall low byte", 32'(mem[8'h0A]), 32'h33);
    chk("R4 lcall high byte", 32'(mem[8'h0B]), 32'h02);
    chk("R3 R2 acall low byte first", 32'(mem[8'h08]), 32'h00);
    chk("R3 R2 acall high byte", 32'(mem[8'h09]), 32'h10);

    // R8 wrap by unmatched returns
    for (int k = 0; k < 4; k++) run(3'd3, 16'h0, 8'h0, 8'h0, 8'h0, 0, 3'd0);
    chk("R8 sp wrap on pop", 32'(sp), 32'hFF);
    run(3'd2, 16'h0000, 8'h00, 8'hAB, 8'hCD, 0, 3'd0);
    chk("R8 sp wrap on push", 32'(sp), 32'h01);
    chk("R8 R4 pc", 32'(pc), 32'hABCD);
    chk("R8 low byte at 00", 32'(mem[8'h00]), 32'h03);
    chk("R8 high byte at 01", 32'(mem[8'h01]), 32'h00);
    run(3'd3, 16'h0, 8'h0, 8'h0, 8'h0, 0, 3'd0);
    chk("R8 R5 pop across wrap", 32'(pc), 32'h0003);
    chk("R8 sp after pop", 32'(sp), 32'hFF);

    // R10 busy: second code held through access cycles
    run(3'd5, 16'h2000, 8'h00, 8'h10, 8'h00, 2, 3'd2);
    chk("R10 busy ignored pc", 32'(pc), 32'h2012);
    chk("R10 busy ignored sp", 32'(sp), 32'hFF);
    lat = 0;
    repeat (5) begin @(negedge clk); if (done) lat++; end
    chk("R10 no extra done", 32'(lat), 32'd0);

    // R10 illegal code
    @(negedge clk); valid = 1'b1; cmd = 3'd7; b1 = 8'h40;
    @(negedge clk); valid = 1'b0;
    lat = 0;
    repeat (5) begin @(negedge clk); if (done || we || re) lat++; end
    chk("R10 illegal code no activity", 32'(lat), 32'd0);
    chk("R10 illegal code pc", 32'(pc), 32'h2012);
    chk("R10 illegal code sp", 32'(sp), 32'hFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule